// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block is a Clause 22 management-interface master that software drives through a small word-addressed register port. One 32-bit command word carries the complete transaction: PHY address, register address, direction and, for writes, the 16-bit payload. A valid bit in that word marks it as a real command. Once a command is accepted, the block builds the serial management frame and shifts it out on MDC/MDIO. During the read turnaround it releases the data line. It then collects the PHY's answer into a result register.

Two status flags let software pace itself. The queued flag shows that a command has been latched and is waiting for the serial engine. The in-flight flag shows that a frame is on the wire. A write only needs to be issued. A read is complete when both flags are low, and the result is then read from the data register. The upper bits of that register report a turnaround fault, which marks the returned value as unusable.

MDC comes from a free-running divider of the system clock. MDIO changes only after an MDC falling edge and is sampled just after a rising edge.

Top module: `mdio_master`

## Requirements
- R1: After reset the status and result registers read zero, MDC is low and MDIO is released (output enable low).
- R2: Register reads return data one cycle after the read strobe. Status is at byte offset 0x0, the command register at 0x8 and the result register at 0xC. Reads of the command register or of any other offset return zero.
- R3: A write to offset 0x8 is accepted only when bit 31 of the written word is set. A write with bit 31 clear leaves the status at zero and starts no frame.
- R4: Status bit 2 (queued) reads 1 in the cycle right after an accepted command. It clears in the cycle the engine takes the command, which is one cycle later when the engine is idle.
- R5: Status bit 3 (in flight) is 1 from the moment the engine takes a command until the last frame bit has been sampled. While it is 0, MDIO is released.
- R6: Command fields sit at fixed positions: bits 29:25 hold the PHY address, bits 24:20 the register address, bits 19:4 the write data, and bit 2 selects read (otherwise write). Each frame is 32 ones, then 01, then opcode 10 for read or 01 for write, then PHY address, then register address, all MSB first.
- R7: A write frame drives turnaround 1 then 0, followed by the 16 write-data bits MSB first. A write leaves the result register unchanged.
- R8: A read frame releases MDIO from the first turnaround bit to the end of the frame. The 16 bits sampled after turnaround appear MSB first in result bits 15:0.
- R9: If MDIO is not low at the second read-turnaround bit, result bit 16 is set. Bit 17 always reads 0, and both error bits are refreshed by every read.
- R10: A command write that arrives while the queued flag is high is ignored. The queued command keeps its fields and runs once the current frame ends.
- R11: MDC stays high and stays low for MDC_HALF system cycles each, and the MDIO output changes only in the cycle after an MDC falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the pin |

## Verification
Write frames carry payloads with alternating bits and differing PHY and register addresses. A wrong field position or bit order shows up as a mismatch at a specific frame bit. Read frames return values with only the extreme bits set and values with mixed bits, which separates shift direction from an off-by-one in the capture window. A read whose PHY leaves the second turnaround bit high is followed by a clean read, to confirm that the error flag is set and later cleared. Three further cases cover the command queue: a command with its valid bit clear, a command written while another frame is running, and a third command written while that one is still queued.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 4;
  localparam int WORD_W     = 32;
  localparam int DATA_W     = 16;
  localparam int PADDR_W    = 5;
  localparam int FRAME_BITS = 64;
  localparam int PREAMBLE   = 32;
  localparam int TA_FIRST   = 46;                 // index of first turnaround bit
  localparam int TA_SECOND  = TA_FIRST + 1;
  localparam int DATA_FIRST = TA_FIRST + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  localparam logic [ADDR_W-1:0] OFF_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_RESULT = 4'hC;

  localparam int BIT_VALID  = 31;
  localparam int BIT_READ   = 2;
  localparam int BIT_QUEUED = 2;
  localparam int BIT_FLIGHT = 3;

  typedef struct packed {
    logic                rd;
    logic [PADDR_W-1:0]  phy;
    logic [PADDR_W-1:0]  regad;
    logic [DATA_W-1:0]   wdata;
  } mgmt_cmd_t;

  typedef struct packed {
    logic                ta_err;
    logic [DATA_W-1:0]   value;
  } mgmt_res_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      mdc       <= 1'b0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
    end else begin
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      if (cnt == LAST) begin
        cnt       <= '0;
        mdc       <= ~mdc;
        rise_tick <= ~mdc;
        fall_tick <= mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (rst) rise_tick |-> mdc);   // R11
  AST_FALL_LOW:  assert property (@(posedge clk) disable iff (rst) fall_tick |-> !mdc);  // R11
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              take,
  input  logic              busy,
  input  logic              res_valid,
  input  mgmt_res_t         res,
  output logic              pending,
  output mgmt_cmd_t         cmd_q
);
  mgmt_res_t res_q;
  logic      accept;

  assign accept = reg_wr && (reg_addr == OFF_CMD) && reg_wdata[BIT_VALID] && !pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      cmd_q     <= '0;
      res_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (take) pending <= 1'b0;
      if (accept) begin
        pending     <= 1'b1;
        cmd_q.rd    <= reg_wdata[BIT_READ];
        cmd_q.phy   <= reg_wdata[29:25];
        cmd_q.regad <= reg_wdata[24:20];
        cmd_q.wdata <= reg_wdata[19:4];
      end
      if (res_valid) res_q <= res;
      if (reg_rd) begin
        unique case (reg_addr)
          OFF_STATUS: begin
            reg_rdata             <= '0;
            reg_rdata[BIT_QUEUED] <= pending;
            reg_rdata[BIT_FLIGHT] <= busy;
          end
          OFF_RESULT: reg_rdata <= {{(WORD_W-DATA_W-1){1'b0}}, res_q};
          default:    reg_rdata <= '0;
        endcase
      end
    end
  end

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst) take |=> !pending);  // R4
  AST_QUEUE_HELD:  assert property (@(posedge clk) disable iff (rst)
                     (pending && !take) |=> (pending && $stable(cmd_q)));                 // R10
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pending,
  input  mgmt_cmd_t  cmd_q,
  input  logic       rise_tick,
  input  logic       fall_tick,
  input  logic       mdio_in,
  output logic       take,
  output logic       busy,
  output logic       mdio_out,
  output logic       mdio_oe,
  output logic       res_valid,
  output mgmt_res_t  res
);
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bits_out;
  logic                  op_rd;
  logic [DATA_W-1:0]     rx;
  logic                  err;

  assign take = pending && !busy;
  assign res  = '{ta_err: err, value: rx};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      frame     <= '0;
      bits_out  <= '0;
      op_rd     <= 1'b0;
      rx        <= '0;
      err       <= 1'b0;
      mdio_out  <= 1'b1;
      mdio_oe   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (take) begin
        busy     <= 1'b1;
        bits_out <= '0;
        op_rd    <= cmd_q.rd;
        err      <= 1'b0;
        frame    <= {{PREAMBLE{1'b1}}, 2'b01,
                     (cmd_q.rd ? 2'b10 : 2'b01),
                     cmd_q.phy, cmd_q.regad,
                     (cmd_q.rd ? 2'b11 : 2'b10),
                     (cmd_q.rd ? {DATA_W{1'b1}} : cmd_q.wdata)};
      end else if (busy && fall_tick && (bits_out < CNT_W'(FRAME_BITS))) begin
        mdio_out <= frame[FRAME_BITS-1];
        frame    <= {frame[FRAME_BITS-2:0], 1'b0};
        bits_out <= bits_out + 1'b1;
        mdio_oe  <= !(op_rd && (bits_out >= CNT_W'(TA_FIRST)));
      end else if (busy && rise_tick && (bits_out != '0)) begin
        if (op_rd && (bits_out == CNT_W'(TA_SECOND + 1)) && mdio_in) err <= 1'b1;
        if (bits_out > CNT_W'(DATA_FIRST)) rx <= {rx[DATA_W-2:0], mdio_in};
        if (bits_out == CNT_W'(FRAME_BITS)) begin
          busy      <= 1'b0;
          mdio_oe   <= 1'b0;
          res_valid <= op_rd;
        end
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdio_oe);  // R5
  AST_READ_RELEASE:  assert property (@(posedge clk) disable iff (rst)
                       (busy && op_rd && (bits_out > CNT_W'(TA_FIRST))) |-> !mdio_oe);       // R8
  AST_OUT_ON_FALL:   assert property (@(posedge clk) disable iff (rst)
                       !fall_tick |=> $stable(mdio_out));                                    // R11
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  logic      rise_tick, fall_tick;
  logic      take, busy, pending, res_valid;
  mgmt_cmd_t cmd_q;
  mgmt_res_t res;

  mdio_clkdiv #(.HALF(MDC_HALF)) u_div (
    .clk(clk), .rst(rst), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_regs u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take(take), .busy(busy),
    .res_valid(res_valid), .res(res), .pending(pending), .cmd_q(cmd_q)
  );

  mdio_engine u_eng (
    .clk(clk), .rst(rst), .pending(pending), .cmd_q(cmd_q), .rise_tick(rise_tick),
    .fall_tick(fall_tick), .mdio_in(mdio_in), .take(take), .busy(busy),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .res_valid(res_valid), .res(res)
  );
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0, fails = 0, stray = 0, idle_cnt = 0;
  int exp_q[$];
  int drv_q[$];
  bit armed = 0, live = 0, finished = 0;

  always #2 clk = ~clk;

  mdio_master #(.MDC_HALF(HALF)) u_mdio_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_cmd(bit vld, bit rd, logic [4:0] phy, logic [4:0] ra,
                                         logic [15:0] wd);
    return {vld, 1'b0, phy, ra, wd, 1'b0, rd, ~rd, 1'b0};
  endfunction

  // Expected wire model: 0/1 = driven value, 2 = released; drv_q = what the PHY puts on the line
  task automatic push_frame(bit rd, logic [4:0] phy, logic [4:0] ra, logic [15:0] wd,
                            logic [15:0] phy_val, bit fault);
    logic [13:0] head;
    head = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra};
    for (int i = 0; i < 32; i++) begin exp_q.push_back(1); drv_q.push_back(1); end
    for (int i = 13; i >= 0; i--) begin exp_q.push_back(int'(head[i])); drv_q.push_back(1); end
    if (rd) begin
      exp_q.push_back(2); drv_q.push_back(1);
      exp_q.push_back(2); drv_q.push_back(fault ? 1 : 0);
      for (int i = 15; i >= 0; i--) begin exp_q.push_back(2); drv_q.push_back(int'(phy_val[i])); end
    end else begin
      exp_q.push_back(1); drv_q.push_back(1);
      exp_q.push_back(0); drv_q.push_back(1);
      for (int i = 15; i >= 0; i--) begin exp_q.push_back(int'(wd[i])); drv_q.push_back(1); end
    end
  endtask

  always @(negedge mdc) begin
    if (armed && exp_q.size() > 0) live = 1;
    if (live && drv_q.size() > 0) mdio_in = drv_q[0][0];
    else mdio_in = 1'b1;
  end

  always @(posedge mdc) begin
    if (live && exp_q.size() > 0) begin
      int e, pos;
      pos = (64 - (exp_q.size() % 64)) % 64;
      e = exp_q.pop_front();
      void'(drv_q.pop_front());
      if (e == 2) chk(mdio_oe == 1'b0, "R8 released bit", mdio_oe, 0);
      else if (pos < 46) chk(mdio_oe && (mdio_out == e[0]), "R6 header bit", {mdio_oe, mdio_out}, 2 + e);
      else chk(mdio_oe && (mdio_out == e[0]), "R7 write TA/data bit", {mdio_oe, mdio_out}, 2 + e);
      if (exp_q.size() == 0) begin live = 0; armed = 0; end
    end
  end

  always @(negedge clk) begin
    if (exp_q.size() == 0) idle_cnt++; else idle_cnt = 0;
    if (idle_cnt > 4 && mdio_oe) stray++;
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    s = 32'hFFFF_FFFF;
    for (int i = 0; i < 3000 && s != 0; i++) bus_read(4'h0, s);
    chk(s == 0, req, s, 0);
  endtask

  task automatic issue(bit rd, logic [4:0] phy, logic [4:0] ra, logic [15:0] wd,
                       logic [15:0] pv, bit fault);
    push_frame(rd, phy, ra, wd, pv, fault);
    bus_write(4'h8, mk_cmd(1'b1, rd, phy, ra, wd));
    armed = 1;
  endtask

  initial begin
    logic [31:0] d;
    realtime t0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset", {mdc, mdio_oe}, 0);
    bus_read(4'h0, d); chk(d == 0, "R1 status after reset", d, 0);
    bus_read(4'hC, d); chk(d == 0, "R1 result after reset", d, 0);
    bus_read(4'h8, d); chk(d == 0, "R2 command offset reads zero", d, 0);
    bus_read(4'h4, d); chk(d == 0, "R2 unmapped offset reads zero", d, 0);

    @(posedge mdc); t0 = $realtime;
    @(negedge mdc);
    chk(int'(($realtime - t0) / 4.0) == HALF, "R11 MDC high time", int'(($realtime - t0) / 4.0), HALF);

    // Write frame, alternating payload
    issue(1'b0, 5'h05, 5'h03, 16'hA5C3, 16'h0, 1'b0);
    bus_read(4'h0, d); chk(d == 32'h4, "R4 queued right after accept", d, 4);
    bus_read(4'h0, d); chk(d == 32'h8, "R5 in flight after take", d, 8);
    wait_idle("R5 in-flight clears after write");
    chk(exp_q.size() == 0, "R6 write frame fully seen", exp_q.size(), 0);
    bus_read(4'hC, d); chk(d == 0, "R7 write leaves result unchanged", d, 0);

    // Read frames
    issue(1'b1, 5'h1F, 5'h1A, 16'h0, 16'h3C96, 1'b0);
    wait_idle("R5 in-flight clears after read");
    bus_read(4'hC, d); chk(d == 32'h3C96, "R8 read value", d, 32'h3C96);

    issue(1'b1, 5'h0A, 5'h05, 16'h0, 16'h1234, 1'b1);
    wait_idle("R5 idle after faulty read");
    bus_read(4'hC, d); chk(d == 32'h11234, "R9 turnaround fault flag", d, 32'h11234);

    issue(1'b1, 5'h00, 5'h1F, 16'h0, 16'h8001, 1'b0);
    wait_idle("R5 idle after clean read");
    bus_read(4'hC, d); chk(d == 32'h8001, "R9 error cleared, bit 17 zero", d, 32'h8001);

    // Command without valid bit
    bus_write(4'h8, mk_cmd(1'b0, 1'b1, 5'h04, 5'h04, 16'h0));
    bus_read(4'h0, d); chk(d == 0, "R3 invalid command not queued", d, 0);
    repeat (200) @(negedge clk);
    bus_read(4'h0, d); chk(d == 0 && stray == 0, "R3 no frame from invalid command", stray, 0);

    // Queueing: A running, B queued, C ignored
    issue(1'b0, 5'h01, 5'h02, 16'h5555, 16'h0, 1'b0);
    repeat (10) @(negedge clk);
    push_frame(1'b1, 5'h02, 5'h07, 16'h0, 16'h5A5A, 1'b0);
    bus_write(4'h8, mk_cmd(1'b1, 1'b1, 5'h02, 5'h07, 16'h0));
    bus_read(4'h0, d); chk(d == 32'hC, "R10 queued behind running frame", d, 32'hC);
    bus_write(4'h8, mk_cmd(1'b1, 1'b0, 5'h03, 5'h09, 16'hFFFF));
    bus_read(4'h0, d); chk(d == 32'hC, "R10 status after ignored write", d, 32'hC);
    wait_idle("R10 queue drains");
    bus_read(4'hC, d); chk(d == 32'h5A5A, "R10 queued read kept its fields", d, 32'h5A5A);
    repeat (400) @(negedge clk);
    chk(exp_q.size() == 0 && stray == 0, "R10 ignored command never ran", stray, 0);
    bus_read(4'h0, d); chk(d == 0, "R10 idle at end", d, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule